// File: doc/BRIEF.md
# Lane-Rate Band Code Selector

This block turns a requested per-lane data rate in Mbps into the two tuning words a high-speed serial receiver front end needs: a 7-bit band code and a 9-bit delay-line frequency word. Both come from a constant table of 63 ascending rates between 80 and 2500 Mbps. A start pulse captures the request. The block then walks the table one entry per clock until it reaches the first entry at or above the request. It picks whichever of that entry and the one before it lies closer, and a tie goes to the lower rate.

In the same run, the block derives a configuration-clock range code from the configuration clock frequency in MHz. It also rejects any request whose rate or lane count falls outside the limits of the chosen variant. The low-rate variant accepts up to 1500 Mbps and 2 lanes, with a 6-bit range code. The high-rate variant accepts up to 2500 Mbps and 4 lanes, with an 8-bit range code. Software or a bring-up sequencer pulses start, waits for the done or error flag, and then copies the outputs into the receiver's tuning fields.

Top module: `rate_band_sel`

## Requirements
- R1: A rate below 80 or above the variant maximum (2500 when HIGH_RATE=1, 1500 when HIGH_RATE=0) sets err_o and leaves done_o low. Rates of exactly 80 and exactly the maximum are accepted.
- R2: A lane count above the variant maximum (4 when HIGH_RATE=1, 2 when HIGH_RATE=0) sets err_o and leaves done_o low.
- R3: A rate equal to a table entry returns the band code of that entry. Examples: 80→0x00, 1000→0x0A, 1500→0x2C, 1550→0x3D, 2000→0x0F, 2500→0x49.
- R4: A rate between two entries returns the entry nearest to it. When both entries are equally far away, the lower one wins. Examples: 1525→0x2C, 1526→0x3D, 2075→0x40.
- R5: The delay-line word is 489 for every entry up to 1500 Mbps. Above that it takes a per-entry value between 303 and 411. Examples: 1550→303, 2000→391, 2050→401, 2100 and above→411.
- R6: cfg_code_o equals (cfg_mhz_i − 17) × 4, reduced modulo 2^CFG_W. CFG_W is 8 when HIGH_RATE=1 and 6 when HIGH_RATE=0.
- R7: For an accepted request whose first table entry at or above the rate has index k (counting from 0), done_o goes high k+2 clock edges after the edge that samples start_i.
- R8: On a rejected request, err_o is high after the edge that samples start_i, and band_o, ddl_o and cfg_code_o keep their previous values. done_o and err_o are never high together, and both hold until the next accepted start.
- R9: A start_i pulse that arrives while a search is in progress is ignored. The running search finishes with the rate captured at its own start.
- R10: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse that captures a request |
| rate_i | input | RATE_W | Requested lane rate in Mbps |
| cfg_mhz_i | input | MHZ_W | Configuration clock frequency in MHz |
| lanes_i | input | LANE_W | Requested lane count |
| band_o | output | BAND_W | Selected band code |
| ddl_o | output | DDL_W | Selected delay-line frequency word |
| cfg_code_o | output | CFG_W | Configuration-clock range code |
| done_o | output | 1 | Selection complete; held until the next accepted start |
| err_o | output | 1 | Request rejected; held until the next accepted start |

## Verification
The first set of rates lands exactly on table entries at the low end, the middle, both sides of the 1500/1550 delay-line break and the top of the table. These cases catch errors in the stored band and delay-line values. The second set places rates one step below, exactly at and one step above the midpoint between two entries. This separates a correct lower-wins tie rule from a nearest-above or strictly-nearer rule. The third set uses rates and lane counts just inside and just outside each limit, on both variants. It shows that the bounds are inclusive and that a rejected request leaves the previous result intact. Finally, latency is measured at two table positions, and a start is issued while a search is running. Together these show that the search advances one entry per cycle and that a busy search ignores a new start.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

   localparam int RBS_ENTRIES  = 63;
   localparam int RBS_IDX_W    = 6;
   localparam int RBS_MIN_RATE = 80;

   typedef enum logic [1:0] {
      RBS_IDLE,
      RBS_SCAN,
      RBS_PICK
   } rbs_state_e;

   // Rate of a table slot; the slot after the last entry reads as zero.
   function automatic int rbs_rate_of(input int i);
      if (i < 12)               return 80 + 10 * i;
      else if (i < 16)          return 205 + 15 * (i - 12);
      else if (i < 20)          return 275 + 25 * (i - 16);
      else if (i < RBS_ENTRIES) return 400 + 50 * (i - 20);
      else                      return 0;
   endfunction

   // Delay-line word of a table slot.
   function automatic int rbs_ddl_of(input int i);
      if (i <= 42)              return 489;
      else if (i >= RBS_ENTRIES) return 0;
      else if (i >= 54)         return 411;
      else begin
         case (i)
            43: return 303;
            44: return 313;
            45: return 323;
            46: return 333;
            47: return 342;
            48: return 352;
            49: return 362;
            50: return 372;
            51: return 381;
            52: return 391;
            default: return 401;
         endcase
      end
   endfunction

endpackage

// File: rtl/rbs_rate_rom.sv
module rbs_rate_rom
   import rbs_pkg::*;
#(
   parameter int RATE_W = 12,
   parameter int BAND_W = 7,
   parameter int DDL_W  = 9
) (
   input  logic [RBS_IDX_W-1:0] idx_i,
   output logic [RATE_W-1:0]    rate_o,
   output logic [BAND_W-1:0]    band_o,
   output logic [DDL_W-1:0]     ddl_o
);

   always_comb begin
      rate_o = RATE_W'(rbs_rate_of(int'(idx_i)));
      ddl_o  = DDL_W'(rbs_ddl_of(int'(idx_i)));
   end

   always_comb begin
      case (idx_i)
         6'd0:  band_o = BAND_W'(7'h00);
         6'd1:  band_o = BAND_W'(7'h10);
         6'd2:  band_o = BAND_W'(7'h20);
         6'd3:  band_o = BAND_W'(7'h30);
         6'd4:  band_o = BAND_W'(7'h01);
         6'd5:  band_o = BAND_W'(7'h11);
         6'd6:  band_o = BAND_W'(7'h21);
         6'd7:  band_o = BAND_W'(7'h31);
         6'd8:  band_o = BAND_W'(7'h02);
         6'd9:  band_o = BAND_W'(7'h12);
         6'd10: band_o = BAND_W'(7'h22);
         6'd11: band_o = BAND_W'(7'h32);
         6'd12: band_o = BAND_W'(7'h03);
         6'd13: band_o = BAND_W'(7'h13);
         6'd14: band_o = BAND_W'(7'h23);
         6'd15: band_o = BAND_W'(7'h33);
         6'd16: band_o = BAND_W'(7'h04);
         6'd17: band_o = BAND_W'(7'h14);
         6'd18: band_o = BAND_W'(7'h25);
         6'd19: band_o = BAND_W'(7'h35);
         6'd20: band_o = BAND_W'(7'h05);
         6'd21: band_o = BAND_W'(7'h16);
         6'd22: band_o = BAND_W'(7'h26);
         6'd23: band_o = BAND_W'(7'h37);
         6'd24: band_o = BAND_W'(7'h07);
         6'd25: band_o = BAND_W'(7'h18);
         6'd26: band_o = BAND_W'(7'h28);
         6'd27: band_o = BAND_W'(7'h39);
         6'd28: band_o = BAND_W'(7'h09);
         6'd29: band_o = BAND_W'(7'h19);
         6'd30: band_o = BAND_W'(7'h29);
         6'd31: band_o = BAND_W'(7'h3a);
         6'd32: band_o = BAND_W'(7'h0a);
         6'd33: band_o = BAND_W'(7'h1a);
         6'd34: band_o = BAND_W'(7'h2a);
         6'd35: band_o = BAND_W'(7'h3b);
         6'd36: band_o = BAND_W'(7'h0b);
         6'd37: band_o = BAND_W'(7'h1b);
         6'd38: band_o = BAND_W'(7'h2b);
         6'd39: band_o = BAND_W'(7'h3c);
         6'd40: band_o = BAND_W'(7'h0c);
         6'd41: band_o = BAND_W'(7'h1c);
         6'd42: band_o = BAND_W'(7'h2c);
         6'd43: band_o = BAND_W'(7'h3d);
         6'd44: band_o = BAND_W'(7'h0d);
         6'd45: band_o = BAND_W'(7'h1d);
         6'd46: band_o = BAND_W'(7'h2e);
         6'd47: band_o = BAND_W'(7'h3e);
         6'd48: band_o = BAND_W'(7'h0e);
         6'd49: band_o = BAND_W'(7'h1e);
         6'd50: band_o = BAND_W'(7'h1f);
         6'd51: band_o = BAND_W'(7'h3f);
         6'd52: band_o = BAND_W'(7'h0f);
         6'd63: band_o = '0;
         default: band_o = BAND_W'(7'h40 + 7'(idx_i - 6'd53));
      endcase
   end

endmodule

// File: rtl/rbs_bound_chk.sv
module rbs_bound_chk
   import rbs_pkg::*;
#(
   parameter int RATE_W    = 12,
   parameter int LANE_W    = 3,
   parameter int MAX_RATE  = 2500,
   parameter int MAX_LANES = 4
) (
   input  logic [RATE_W-1:0] rate_i,
   input  logic [LANE_W-1:0] lanes_i,
   output logic              bad_o
);

   logic rate_low, rate_high, lane_high;

   always_comb begin
      rate_low  = rate_i < RATE_W'(RBS_MIN_RATE);
      rate_high = rate_i > RATE_W'(MAX_RATE);
      lane_high = lanes_i > LANE_W'(MAX_LANES);
      bad_o     = rate_low | rate_high | lane_high;
   end

endmodule

// File: rtl/rbs_scan_ctrl.sv
module rbs_scan_ctrl
   import rbs_pkg::*;
#(
   parameter int RATE_W   = 12,
   parameter int MAX_RATE = 2500
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic                 bad_i,
   input  logic [RATE_W-1:0]    rate_i,
   input  logic [RATE_W-1:0]    rom_rate_i,
   output logic [RBS_IDX_W-1:0] rom_idx_o,
   output logic                 accept_o,
   output logic                 load_o,
   output logic                 fail_o
);

   rbs_state_e             state_q;
   logic [RBS_IDX_W-1:0]   idx_q, sel_q;
   logic [RATE_W-1:0]      req_q, prev_q;
   logic                   hit, sentinel, take_lo, accept;

   always_comb begin
      accept    = start_i && (state_q == RBS_IDLE);
      sentinel  = (rom_rate_i == '0);
      hit       = !sentinel && (rom_rate_i >= req_q);
      take_lo   = (idx_q != '0) && ((req_q - prev_q) <= (rom_rate_i - req_q));
      rom_idx_o = (state_q == RBS_PICK) ? sel_q : idx_q;
      accept_o  = accept;
      load_o    = (state_q == RBS_PICK);
      fail_o    = (accept && bad_i) || ((state_q == RBS_SCAN) && sentinel);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RBS_IDLE;
         idx_q   <= '0;
         sel_q   <= '0;
         req_q   <= '0;
         prev_q  <= '0;
      end else begin
         case (state_q)
            RBS_IDLE: begin
               if (accept && !bad_i) begin
                  state_q <= RBS_SCAN;
                  idx_q   <= '0;
                  prev_q  <= '0;
                  req_q   <= rate_i;
               end
            end
            RBS_SCAN: begin
               if (sentinel) begin
                  state_q <= RBS_IDLE;
               end else if (hit) begin
                  state_q <= RBS_PICK;
                  sel_q   <= take_lo ? (idx_q - 1'b1) : idx_q;
               end else begin
                  idx_q  <= idx_q + 1'b1;
                  prev_q <= rom_rate_i;
               end
            end
            default: state_q <= RBS_IDLE;
         endcase
      end
   end

   AST_SCAN_IN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RBS_SCAN) |-> (req_q >= RATE_W'(RBS_MIN_RATE) && req_q <= RATE_W'(MAX_RATE))); // R1

   AST_SCAN_BELOW_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RBS_SCAN && idx_q != '0) |-> (prev_q < req_q)); // R4

endmodule

// File: rtl/rate_band_sel.sv
module rate_band_sel
   import rbs_pkg::*;
#(
   parameter int HIGH_RATE = 1,
   parameter int RATE_W    = 12,
   parameter int MHZ_W     = 8,
   parameter int LANE_W    = 3,
   parameter int BAND_W    = 7,
   parameter int DDL_W     = 9,
   parameter int CFG_W     = (HIGH_RATE != 0) ? 8 : 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [RATE_W-1:0] rate_i,
   input  logic [MHZ_W-1:0]  cfg_mhz_i,
   input  logic [LANE_W-1:0] lanes_i,
   output logic [BAND_W-1:0] band_o,
   output logic [DDL_W-1:0]  ddl_o,
   output logic [CFG_W-1:0]  cfg_code_o,
   output logic              done_o,
   output logic              err_o
);

   localparam int MAX_RATE  = (HIGH_RATE != 0) ? 2500 : 1500;
   localparam int MAX_LANES = (HIGH_RATE != 0) ? 4 : 2;
   localparam int CALC_W    = MHZ_W + 2;

   generate
      if (HIGH_RATE != 0 && HIGH_RATE != 1) begin : g_bad_variant
         $error("rate_band_sel: HIGH_RATE must be 0 or 1");
      end
      if (RATE_W < 12) begin : g_bad_rate_w
         $error("rate_band_sel: RATE_W too narrow for the table");
      end
      if (BAND_W < 7 || DDL_W < 9) begin : g_bad_out_w
         $error("rate_band_sel: band or delay-line width too narrow");
      end
      if (CFG_W > CALC_W) begin : g_bad_cfg_w
         $error("rate_band_sel: CFG_W wider than the range calculation");
      end
      if ((1 << LANE_W) <= MAX_LANES) begin : g_bad_lane_w
         $error("rate_band_sel: LANE_W cannot express an over-limit lane count");
      end
   endgenerate

   logic                 bad, accept, load, fail;
   logic [RBS_IDX_W-1:0] rom_idx;
   logic [RATE_W-1:0]    rom_rate;
   logic [BAND_W-1:0]    rom_band;
   logic [DDL_W-1:0]     rom_ddl;
   logic [MHZ_W-1:0]     mhz_q;
   logic [CALC_W-1:0]    cfg_full;

   rbs_bound_chk #(
      .RATE_W   (RATE_W),
      .LANE_W   (LANE_W),
      .MAX_RATE (MAX_RATE),
      .MAX_LANES(MAX_LANES)
   ) u_bound (
      .rate_i (rate_i),
      .lanes_i(lanes_i),
      .bad_o  (bad)
   );

   rbs_scan_ctrl #(
      .RATE_W  (RATE_W),
      .MAX_RATE(MAX_RATE)
   ) u_scan (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .bad_i     (bad),
      .rate_i    (rate_i),
      .rom_rate_i(rom_rate),
      .rom_idx_o (rom_idx),
      .accept_o  (accept),
      .load_o    (load),
      .fail_o    (fail)
   );

   rbs_rate_rom #(
      .RATE_W(RATE_W),
      .BAND_W(BAND_W),
      .DDL_W (DDL_W)
   ) u_rom (
      .idx_i (rom_idx),
      .rate_o(rom_rate),
      .band_o(rom_band),
      .ddl_o (rom_ddl)
   );

   always_comb begin
      cfg_full = ({2'b00, mhz_q} - CALC_W'(17)) << 2;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mhz_q      <= '0;
         band_o     <= '0;
         ddl_o      <= '0;
         cfg_code_o <= '0;
         done_o     <= 1'b0;
         err_o      <= 1'b0;
      end else begin
         if (accept) begin
            mhz_q  <= cfg_mhz_i;
            done_o <= 1'b0;
            err_o  <= 1'b0;
         end
         if (fail) begin
            err_o <= 1'b1;
         end
         if (load) begin
            band_o     <= rom_band;
            ddl_o      <= rom_ddl;
            cfg_code_o <= cfg_full[CFG_W-1:0];
            done_o     <= 1'b1;
         end
      end
   end

   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o)); // R8

   AST_ERR_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> ($stable(band_o) && $stable(ddl_o) && $stable(cfg_code_o))); // R8

   AST_DDL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (ddl_o >= DDL_W'(303) && ddl_o <= DDL_W'(489))); // R5

   AST_DONE_AFTER_PICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(load)); // R7

endmodule

// File: tb/rate_band_sel_bench.sv
module rate_band_sel_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 17;

   //                          0    1     2     3     4     5     6     7     8     9    10   11    12    13   14    15    16
   localparam int V_RATE [NV] = '{80, 1000, 1500, 1550, 2000, 2500, 1524, 1525, 1526, 212, 85, 2075, 2110, 79, 2501, 2000, 349};
   localparam int V_MHZ  [NV] = '{24, 24,   30,   24,   24,   24,   24,   24,   24,   24,  24, 24,   40,   24, 24,   24,   24};
   localparam int V_LANE [NV] = '{1,  2,    4,    4,    3,    4,    1,    1,    1,    1,   1,  1,    1,    1,  1,    5,    1};
   localparam int V_ERR  [NV] = '{0,  0,    0,    0,    0,    0,    0,    0,    0,    0,   0,  0,    0,    1,  1,    1,    0};
   localparam int V_BAND [NV] = '{'h00,'h0A,'h2C,'h3D,'h0F,'h49,'h2C,'h2C,'h3D,'h03,'h00,'h40,'h41, 0, 0, 0, 'h35};
   localparam int V_DDL  [NV] = '{489,489, 489, 303, 391, 411, 489, 489, 303, 489, 489, 401, 411,  0, 0, 0, 489};
   localparam int V_CFG  [NV] = '{28, 28,   52,   28,   28,   28,   28,   28,   28,   28,  28, 28,   92,   0,  0,    0,    28};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [11:0] rate = '0;
   logic [7:0]  mhz = '0;
   logic [2:0]  lanes = '0;

   logic [6:0]  hi_band, lo_band;
   logic [8:0]  hi_ddl, lo_ddl;
   logic [7:0]  hi_cfg;
   logic [5:0]  lo_cfg;
   logic        hi_done, hi_err, lo_done, lo_err;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rate_band_sel #(.HIGH_RATE(1)) u_rate_band_sel (
      .clk(clk), .rst_n(rst_n), .start_i(start), .rate_i(rate),
      .cfg_mhz_i(mhz), .lanes_i(lanes),
      .band_o(hi_band), .ddl_o(hi_ddl), .cfg_code_o(hi_cfg),
      .done_o(hi_done), .err_o(hi_err)
   );

   rate_band_sel #(.HIGH_RATE(0)) u_rate_band_sel_lo (
      .clk(clk), .rst_n(rst_n), .start_i(start), .rate_i(rate),
      .cfg_mhz_i(mhz), .lanes_i(lanes),
      .band_o(lo_band), .ddl_o(lo_ddl), .cfg_code_o(lo_cfg),
      .done_o(lo_done), .err_o(lo_err)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic pulse_start(input int r, input int m, input int l);
      @(negedge clk);
      rate  = 12'(r);
      mhz   = 8'(m);
      lanes = 3'(l);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_both();
      int n = 0;
      while (!((hi_done || hi_err) && (lo_done || lo_err)) && n < 200) begin
         @(negedge clk);
         n++;
      end
      if (n >= 200) chk("R7", "search timeout", n, 0);
   endtask

   task automatic run(input int r, input int m, input int l);
      pulse_start(r, m, l);
      wait_both();
   endtask

   task automatic latency(input int r, input int k);
      int cnt = 0;
      @(negedge clk);
      rate  = 12'(r);
      mhz   = 8'd24;
      lanes = 3'd1;
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      while (!hi_done && cnt < 100) begin
         @(posedge clk);
         cnt++;
         @(negedge clk);
      end
      chk("R7", "edges from start to done", cnt, k + 2);
      wait_both();
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int pb, pd, pc;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10", "band", int'(hi_band), 0);
      chk("R10", "ddl", int'(hi_ddl), 0);
      chk("R10", "cfg", int'(hi_cfg), 0);
      chk("R10", "done", int'(hi_done), 0);
      chk("R10", "err", int'(hi_err), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      pb = 0; pd = 0; pc = 0;
      for (int v = 0; v < NV; v++) begin
         run(V_RATE[v], V_MHZ[v], V_LANE[v]);
         if (V_ERR[v] != 0) begin
            // R1 R2: rejected; R8: previous result kept
            chk(V_LANE[v] > 4 ? "R2" : "R1", $sformatf("err rate=%0d", V_RATE[v]), int'(hi_err), 1);
            chk("R8", "done low on reject", int'(hi_done), 0);
            chk("R8", "band kept", int'(hi_band), pb);
            chk("R8", "ddl kept", int'(hi_ddl), pd);
            chk("R8", "cfg kept", int'(hi_cfg), pc);
         end else begin
            chk("R1", $sformatf("accepted rate=%0d", V_RATE[v]), int'(hi_done), 1);
            chk("R3 R4", $sformatf("band rate=%0d", V_RATE[v]), int'(hi_band), V_BAND[v]);
            chk("R5", $sformatf("ddl rate=%0d", V_RATE[v]), int'(hi_ddl), V_DDL[v]);
            chk("R6", $sformatf("cfg mhz=%0d", V_MHZ[v]), int'(hi_cfg), V_CFG[v]);
            pb = V_BAND[v]; pd = V_DDL[v]; pc = V_CFG[v];
         end
      end

      // Low-rate variant limits (R1, R2, R6, R8)
      run(1500, 24, 2);
      chk("R1", "low variant 1500 done", int'(lo_done), 1);
      chk("R3", "low variant 1500 band", int'(lo_band), 'h2C);
      run(1501, 24, 2);
      chk("R1", "low variant 1501 err", int'(lo_err), 1);
      chk("R8", "low variant band kept", int'(lo_band), 'h2C);
      run(1000, 24, 3);
      chk("R2", "low variant 3 lanes err", int'(lo_err), 1);
      run(1000, 40, 2);
      chk("R6", "low variant cfg wraps to 6 bits", int'(lo_cfg), 28);
      chk("R2", "high variant 2 lanes fine", int'(hi_done), 1);

      // R7: latency at two table positions
      latency(80, 0);
      latency(400, 20);

      // R9: start while busy is ignored
      pulse_start(2500, 24, 4);
      repeat (5) @(negedge clk);
      rate  = 12'd80;
      lanes = 3'd1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_both();
      while (!hi_done && !hi_err) @(negedge clk);
      chk("R9", "busy start ignored band", int'(hi_band), 'h49);
      chk("R9", "busy start ignored ddl", int'(hi_ddl), 411);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule